// File: doc/BRIEF.md
# Thread-Partitioned In-Order Retire Queue

This block holds micro-ops from allocation until they retire, for a core that runs one to four hardware threads. One storage array of `DEPTH` entries is used either as a single ring owned by thread 0, or it is cut into 2, 3 or 4 equal rings. Each ring has its own head pointer, tail pointer and occupancy count. An allocation names a thread and carries a micro-op tag. The block answers with an accept and the entry index, or with a stall. Each thread has its own completion port, which marks an entry index as finished.

Every cycle the queue retires at most one entry. The only candidates are the oldest entry of each active thread, and only when that entry is marked finished. Threads are served round-robin. Retiring an entry returns its thread, index and tag.

A change of thread count is costly, so the queue takes it in two steps. It first records the request and refuses every allocation. It applies the new count only once all rings are empty, and at that point every ring is re-based for the new count.

Top module: `thread_retire_queue`

## Requirements
- R1: After reset, every thread reports empty and not full, the mode is 0 (one thread), and neither `alloc_ack`, `alloc_stall` nor `ret_valid` is set.
- R2: The mode value m selects m+1 active threads. Each active thread gets a ring of DEPTH/(m+1) entries starting at index tid*DEPTH/(m+1). Successive accepted allocations of one thread return successive indices from that base.
- R3: A thread accepts exactly its ring size of entries and then stalls. A refused allocation writes nothing: the entry at that position still returns its original tag.
- R4: An allocation whose thread ID is greater than the current mode value is refused with `alloc_stall`.
- R5: A ring's pointers wrap from base+size-1 back to base, never into a neighbouring ring.
- R6: The answer comes one cycle after the request. Exactly one of `alloc_ack` and `alloc_stall` is set for each request, and neither is set when there is no request.
- R7: A thread retires only its oldest entry, and only after that entry has been marked. A younger marked entry never retires ahead of it.
- R8: A retirement appears one cycle after its head becomes retirable. It shows `ret_valid` together with the thread, the entry index and the tag written at allocation.
- R9: When several threads can retire, one is served per cycle. The search starts at the thread after the last one that retired, and after reset it starts at thread 0.
- R10: A request on `mode_req_valid` raises `mode_busy`, and from then on every allocation is refused. The new mode takes effect only when every ring is empty. After that, each thread allocates again from its new base.
- R11: `thr_full[t]` is set when active thread t holds its ring size of entries. `thr_empty[t]` is set when thread t holds no entries.
- R12: Completion marks on different threads' ports in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | TW | Thread of the allocation |
| alloc_tag | input | TAG_W | Micro-op tag to store |
| alloc_ack | output | 1 | Previous request accepted |
| alloc_stall | output | 1 | Previous request refused |
| alloc_idx | output | PW | Entry index given to the accepted request |
| cmp_valid | input | NTHR | Per-thread completion mark strobe |
| cmp_idx | input | NTHR*PW | Per-thread entry index to mark, thread t in bits [t*PW +: PW] |
| ret_valid | output | 1 | An entry retired |
| ret_tid | output | TW | Thread of the retired entry |
| ret_idx | output | PW | Index of the retired entry |
| ret_tag | output | TAG_W | Tag of the retired entry |
| mode_req_valid | input | 1 | Request a new thread count |
| mode_req | input | TW | Requested mode (threads minus one) |
| mode_o | output | TW | Current mode (threads minus one) |
| mode_busy | output | 1 | Mode change waiting for the queue to drain |
| thr_full | output | NTHR | Per-thread ring full |
| thr_empty | output | NTHR | Per-thread ring empty |

## Verification
The assertions rely on the following input conditions. A completion mark names only an entry that is currently allocated and not yet marked, and it arrives on the owning thread's port. A requested mode is below NTHR. The bench keeps to these conditions by tracking a model head and tail for each ring and by marking only indices it was given. It sweeps every mode, every thread ID and every fill level of a 12-entry configuration, so the ring sizes 12, 6, 4 and 3 are each filled to the stall point and drained.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // ring size for a mode value (threads minus one)
  function automatic int part_size(int depth, int mode_val);
    return depth / (mode_val + 1);
  endfunction
endpackage

// File: rtl/rq_partition.sv
module rq_partition #(
  parameter int DEPTH = 192,
  parameter int NTHR  = 4,
  parameter int PW    = 8,
  parameter int TW    = 2
) (
  input  logic [TW-1:0] mode,
  output logic [PW-1:0] size,
  output logic [PW-1:0] base [NTHR]
);
  logic [PW-1:0] size_tab [NTHR];

  for (genvar m = 0; m < NTHR; m++) begin : g_tab
    assign size_tab[m] = PW'(rq_pkg::part_size(DEPTH, m));
  end

  assign size = (int'(mode) < NTHR) ? size_tab[mode] : size_tab[0];

  for (genvar t = 0; t < NTHR; t++) begin : g_base
    assign base[t] = PW'(t) * size;
  end
endmodule

// File: rtl/rq_thread.sv
module rq_thread #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reload,
  input  logic          active,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] size,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] count;
  logic [PW-1:0] last_slot;
  logic [PW-1:0] head_inc;
  logic [PW-1:0] tail_inc;

  always_comb begin
    last_slot = base + size - 1'b1;
    head_inc  = (head == last_slot) ? base : head + 1'b1;
    tail_inc  = (tail == last_slot) ? base : tail + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (reload) begin
      head  <= base;
      tail  <= base;
      count <= '0;
    end else begin
      if (push) tail <= tail_inc;
      if (pop)  head <= head_inc;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign full  = active && (count == size);
  assign empty = (count == '0);
endmodule

// File: rtl/rq_rr_arb.sv
module rq_rr_arb #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] last,
  output logic [N-1:0]  grant,
  output logic [TW-1:0] gidx,
  output logic          any
);
  int c;
  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    c     = 0;
    for (int i = 1; i <= N; i++) begin
      c = int'(last) + i;
      if (c >= N) c = c - N;
      if (!any && req[c]) begin
        any      = 1'b1;
        grant[c] = 1'b1;
        gidx     = TW'(c);
      end
    end
  end
endmodule

// File: rtl/thread_retire_queue.sv
module thread_retire_queue #(
  parameter int DEPTH = 192,
  parameter int NTHR  = 4,
  parameter int TAG_W = 8,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_valid,
  input  logic [TW-1:0]      alloc_tid,
  input  logic [TAG_W-1:0]   alloc_tag,
  output logic               alloc_ack,
  output logic               alloc_stall,
  output logic [PW-1:0]      alloc_idx,
  input  logic [NTHR-1:0]    cmp_valid,
  input  logic [NTHR*PW-1:0] cmp_idx,
  output logic               ret_valid,
  output logic [TW-1:0]      ret_tid,
  output logic [PW-1:0]      ret_idx,
  output logic [TAG_W-1:0]   ret_tag,
  input  logic               mode_req_valid,
  input  logic [TW-1:0]      mode_req,
  output logic [TW-1:0]      mode_o,
  output logic               mode_busy,
  output logic [NTHR-1:0]    thr_full,
  output logic [NTHR-1:0]    thr_empty
);
  logic [TW-1:0]    mode_q, tgt_q, last_q;
  logic             pend_q;
  logic             apply;
  logic [TW-1:0]    mode_sel;
  logic [PW-1:0]    part_size;
  logic [PW-1:0]    part_base [NTHR];
  logic [PW-1:0]    head [NTHR];
  logic [PW-1:0]    tail [NTHR];
  logic [NTHR-1:0]  active, push, ready, grant;
  logic [TW-1:0]    gidx;
  logic             any_ret;
  logic             alloc_hit;
  logic [PW-1:0]    tail_sel, head_sel;
  logic [DEPTH-1:0] done_q;
  logic [TAG_W-1:0] mem [DEPTH];
  logic [TAG_W-1:0] rd_q;

  // mode applies only when all rings are empty; no push or pop can happen then
  assign apply    = pend_q && (&thr_empty);
  assign mode_sel = apply ? tgt_q : mode_q;

  rq_partition #(.DEPTH(DEPTH), .NTHR(NTHR), .PW(PW), .TW(TW)) u_part (
    .mode (mode_sel),
    .size (part_size),
    .base (part_base)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign active[t] = (TW'(t) <= mode_q);
    assign push[t]   = alloc_hit && (alloc_tid == TW'(t));
    assign ready[t]  = active[t] && !thr_empty[t] && done_q[head[t]];

    rq_thread #(.PW(PW)) u_thr (
      .clk    (clk),
      .rst    (rst),
      .reload (apply),
      .active (active[t]),
      .push   (push[t]),
      .pop    (grant[t]),
      .base   (part_base[t]),
      .size   (part_size),
      .head   (head[t]),
      .tail   (tail[t]),
      .full   (thr_full[t]),
      .empty  (thr_empty[t])
    );
  end

  rq_rr_arb #(.N(NTHR), .TW(TW)) u_arb (
    .req   (ready),
    .last  (last_q),
    .grant (grant),
    .gidx  (gidx),
    .any   (any_ret)
  );

  assign alloc_hit = alloc_valid && !pend_q && active[alloc_tid] && !thr_full[alloc_tid];
  assign tail_sel  = tail[alloc_tid];
  assign head_sel  = head[gidx];

  // completion flags: cleared on allocation, set by per-thread marks
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++)
        if (push[t]) done_q[tail[t]] <= 1'b0;
      for (int t = 0; t < NTHR; t++)
        if (cmp_valid[t]) done_q[cmp_idx[t*PW +: PW]] <= 1'b1;
    end
  end

  // tag storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (alloc_hit) mem[tail_sel] <= alloc_tag;
    if (any_ret)   rd_q <= mem[head_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= '0;
      tgt_q       <= '0;
      pend_q      <= 1'b0;
      last_q      <= TW'(NTHR - 1);
      alloc_ack   <= 1'b0;
      alloc_stall <= 1'b0;
      alloc_idx   <= '0;
      ret_valid   <= 1'b0;
      ret_tid     <= '0;
      ret_idx     <= '0;
    end else begin
      if (apply) begin
        mode_q <= tgt_q;
        pend_q <= 1'b0;
      end
      if (mode_req_valid) begin
        tgt_q  <= mode_req;
        pend_q <= 1'b1;
      end
      alloc_ack   <= alloc_hit;
      alloc_stall <= alloc_valid && !alloc_hit;
      alloc_idx   <= tail_sel;
      ret_valid   <= any_ret;
      ret_tid     <= gidx;
      ret_idx     <= head_sel;
      if (any_ret) last_q <= gidx;
    end
  end

  assign ret_tag   = rd_q;
  assign mode_o    = mode_q;
  assign mode_busy = pend_q;
endmodule

// File: rtl/rq_check.sv
module rq_check #(
  parameter int NTHR = 4,
  parameter int TW   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            alloc_valid,
  input logic [TW-1:0]   alloc_tid,
  input logic            alloc_ack,
  input logic            alloc_stall,
  input logic            ret_valid,
  input logic [TW-1:0]   ret_tid,
  input logic [TW-1:0]   mode_o,
  input logic            mode_busy,
  input logic [NTHR-1:0] thr_full,
  input logic [NTHR-1:0] thr_empty
);
  logic [NTHR-1:0] empty_d;
  always_ff @(posedge clk) empty_d <= thr_empty;

  assert_one_answer_R6: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |=> (alloc_ack != alloc_stall));

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    !alloc_valid |=> (!alloc_ack && !alloc_stall));

  assert_full_refused_R3: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && thr_full[alloc_tid]) |=> alloc_stall);

  assert_inactive_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && (alloc_tid > mode_o)) |=> alloc_stall);

  assert_pending_refused_R10: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && mode_busy) |=> alloc_stall);

  assert_drained_switch_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_busy) |-> (&thr_empty));

  assert_mode_held_R10: assert property (@(posedge clk) disable iff (rst)
    !$fell(mode_busy) |-> $stable(mode_o));

  assert_flags_apart_R11: assert property (@(posedge clk) disable iff (rst)
    (thr_full & thr_empty) == '0);

  assert_retire_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> !empty_d[ret_tid]);
endmodule

bind thread_retire_queue rq_check #(.NTHR(NTHR), .TW(TW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alloc_valid (alloc_valid),
  .alloc_tid   (alloc_tid),
  .alloc_ack   (alloc_ack),
  .alloc_stall (alloc_stall),
  .ret_valid   (ret_valid),
  .ret_tid     (ret_tid),
  .mode_o      (mode_o),
  .mode_busy   (mode_busy),
  .thr_full    (thr_full),
  .thr_empty   (thr_empty)
);

// File: tb/thread_retire_queue_test.sv
module thread_retire_queue_test;
  localparam int DEPTH = 12, NTHR = 4, TAG_W = 8, PW = 4, TW = 2;

  logic clk = 0, rst = 1;
  logic alloc_valid = 0; logic [TW-1:0] alloc_tid = 0; logic [TAG_W-1:0] alloc_tag = 0;
  logic alloc_ack, alloc_stall; logic [PW-1:0] alloc_idx;
  logic [NTHR-1:0] cmp_valid = 0; logic [NTHR*PW-1:0] cmp_idx = 0;
  logic ret_valid; logic [TW-1:0] ret_tid; logic [PW-1:0] ret_idx; logic [TAG_W-1:0] ret_tag;
  logic mode_req_valid = 0; logic [TW-1:0] mode_req = 0;
  logic [TW-1:0] mode_o; logic mode_busy;
  logic [NTHR-1:0] thr_full, thr_empty;

  thread_retire_queue #(.DEPTH(DEPTH), .NTHR(NTHR), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
    .alloc_tag(alloc_tag), .alloc_ack(alloc_ack), .alloc_stall(alloc_stall),
    .alloc_idx(alloc_idx), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_idx(ret_idx), .ret_tag(ret_tag),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req), .mode_o(mode_o),
    .mode_busy(mode_busy), .thr_full(thr_full), .thr_empty(thr_empty));

  always #2 clk = ~clk;

  int vectors = 0, errs = 0;
  int nlog = 0;
  int log_tid [64]; int log_idx [64]; int log_tag [64];
  int mh [NTHR]; int mt [NTHR];
  int cur_n = 1, cur_sz = DEPTH, last_t = NTHR - 1;

  function automatic int step(int p, int t);
    int b = t * cur_sz;
    return (p == b + cur_sz - 1) ? b : p + 1;
  endfunction

  always @(negedge clk) begin
    if (!rst && ret_valid && nlog < 64) begin
      log_tid[nlog] = int'(ret_tid);
      log_idx[nlog] = int'(ret_idx);
      log_tag[nlog] = int'(ret_tag);
      mh[ret_tid] = step(mh[ret_tid], int'(ret_tid));
      last_t = int'(ret_tid);
      nlog++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alloc(int t, int tag, output bit ack, output bit stall, output int idx);
    alloc_valid = 1; alloc_tid = TW'(t); alloc_tag = TAG_W'(tag);
    @(negedge clk);
    ack = alloc_ack; stall = alloc_stall; idx = int'(alloc_idx);
    alloc_valid = 0;
    if (ack) mt[t] = step(mt[t], t);
  endtask

  task automatic mark1(int t, int idx);
    cmp_valid = '0; cmp_valid[t] = 1'b1; cmp_idx[t*PW +: PW] = PW'(idx);
    @(negedge clk);
    cmp_valid = '0;
  endtask

  task automatic mark_mask(logic [NTHR-1:0] m);
    for (int t = 0; t < NTHR; t++) cmp_idx[t*PW +: PW] = PW'(mh[t]);
    cmp_valid = m;
    @(negedge clk);
    cmp_valid = '0;
  endtask

  task automatic rebase();
    cur_sz = DEPTH / cur_n;
    for (int t = 0; t < NTHR; t++) begin mh[t] = t * cur_sz; mt[t] = t * cur_sz; end
  endtask

  task automatic set_mode(int m);
    mode_req_valid = 1; mode_req = TW'(m);
    @(negedge clk);
    mode_req_valid = 0;
    check(mode_busy == 1'b1, "R10 busy raised", int'(mode_busy), 1);
    for (int i = 0; i < 40 && mode_busy; i++) @(negedge clk);
    check(mode_o == TW'(m) && !mode_busy, "R10 mode applied", int'(mode_o), m);
    cur_n = m + 1;
    rebase();
  endtask

  // R9 expected order: threads in mask, starting after lb
  task automatic check_rr(int lb, logic [NTHR-1:0] m);
    int pos = 0;
    for (int i = 1; i <= NTHR; i++) begin
      int c = (lb + i) % NTHR;
      if (m[c]) begin
        check(log_tid[pos] == c, "R9 round-robin order", log_tid[pos], c);
        pos++;
      end
    end
    check(nlog == pos, "R12 all marks retired", nlog, pos);
  endtask

  initial begin
    bit a, s; int ix, lb;
    for (int t = 0; t < NTHR; t++) begin mh[t] = 0; mt[t] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    check(thr_empty == 4'hF && thr_full == 4'h0, "R1 flags", int'(thr_empty), 15);
    check(mode_o == 0 && !mode_busy, "R1 mode", int'(mode_o), 0);
    check(!alloc_ack && !alloc_stall && !ret_valid, "R1 outputs", int'(alloc_ack), 0);

    // sweep every mode, thread and fill level
    for (int m = 0; m < NTHR; m++) begin
      set_mode(m);
      for (int t = 0; t < NTHR; t++) begin
        for (int k = 0; k <= cur_sz; k++) begin
          alloc(t, t * 16 + k, a, s, ix);
          if (t < cur_n && k < cur_sz)
            check(a && !s && ix == t * cur_sz + k, "R2 index from base", ix, t * cur_sz + k);
          else if (t < cur_n)
            check(s && !a, "R3 stall when full", int'(s), 1);
          else
            check(s && !a, "R4 inactive thread refused", int'(s), 1);
        end
        if (t < cur_n) check(thr_full[t] == 1'b1, "R11 full flag", int'(thr_full[t]), 1);
        else check(thr_empty[t] == 1'b1, "R11 empty flag", int'(thr_empty[t]), 1);
      end
      for (int t = 0; t < cur_n; t++) begin
        nlog = 0;
        for (int k = cur_sz - 1; k >= 1; k--) mark1(t, t * cur_sz + k);
        idle(3);
        check(nlog == 0, "R7 younger waits for head", nlog, 0);
        mark1(t, t * cur_sz);
        idle(cur_sz + 3);
        check(nlog == cur_sz, "R7 in-order retire count", nlog, cur_sz);
        for (int k = 0; k < cur_sz; k++)
          check(log_tid[k] == t && log_idx[k] == t * cur_sz + k && log_tag[k] == t * 16 + k,
                "R8 R3 retired entry", log_tag[k], t * 16 + k);
        check(thr_empty[t] == 1'b1, "R11 empty after drain", int'(thr_empty[t]), 1);
      end
    end

    // wrap inside ring of thread 1 (mode 3, size 3, base 3)
    alloc(1, 8'h51, a, s, ix); check(a && ix == 3, "R5 start at base", ix, 3);
    alloc(1, 8'h52, a, s, ix); check(a && ix == 4, "R5 second", ix, 4);
    mark_mask(4'b0010); idle(3); mark_mask(4'b0010); idle(3);
    alloc(1, 8'h53, a, s, ix); check(a && ix == 5, "R5 last slot", ix, 5);
    alloc(1, 8'h54, a, s, ix); check(a && ix == 3, "R5 wraps to base", ix, 3);
    alloc(1, 8'h55, a, s, ix); check(a && ix == 4, "R5 after wrap", ix, 4);
    check(thr_full[1] == 1'b1, "R11 full after wrap", int'(thr_full[1]), 1);
    nlog = 0;
    for (int i = 0; i < 3; i++) begin mark_mask(4'b0010); idle(3); end
    check(nlog == 3 && log_tag[1] == 8'h54 && log_idx[1] == 3, "R5 R8 wrapped retire", log_tag[1], 8'h54);

    // round-robin with simultaneous marks
    for (int t = 0; t < NTHR; t++) alloc(t, 8'hA0 + t, a, s, ix);
    lb = last_t; nlog = 0;
    mark_mask(4'hF); idle(8);
    check_rr(lb, 4'hF);
    for (int t = 0; t < NTHR; t++) alloc(t, 8'hB0 + t, a, s, ix);
    lb = last_t; nlog = 0;
    mark_mask(4'b0101); idle(6);
    check_rr(lb, 4'b0101);
    lb = last_t; nlog = 0;
    mark_mask(4'b1010); idle(6);
    check_rr(lb, 4'b1010);
    check(thr_empty == 4'hF, "R11 all empty", int'(thr_empty), 15);

    // mode change waits for drain
    alloc(0, 8'hC0, a, s, ix);
    alloc(0, 8'hC1, a, s, ix);
    mode_req_valid = 1; mode_req = 0;
    @(negedge clk);
    mode_req_valid = 0;
    check(mode_busy == 1'b1, "R10 pending", int'(mode_busy), 1);
    alloc(0, 8'hC2, a, s, ix);
    check(s && !a, "R10 alloc refused while pending", int'(s), 1);
    idle(4);
    check(mode_o == 3 && mode_busy, "R10 held until drained", int'(mode_o), 3);
    mark_mask(4'b0001); idle(3); mark_mask(4'b0001); idle(4);
    check(mode_o == 0 && !mode_busy, "R10 applied after drain", int'(mode_o), 0);
    cur_n = 1; rebase();
    alloc(0, 8'hD0, a, s, ix);
    check(a && ix == 0, "R10 R2 new base", ix, 0);
    alloc(1, 8'hD1, a, s, ix);
    check(s && !a, "R4 thread 1 inactive in mode 0", int'(s), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule